// File: doc/BRIEF.md
# SD Host Card Clock and Power Sequencer

This block sits between the fast adapter clock of an SD/MMC host and the card bus. It derives the card clock by dividing the adapter clock, or by passing it straight through. It also walks the card bus through its power phases and turns the bus output drivers on only when the card is fully powered.

The card clock is delivered in three forms:
- a level, `card_clk_o`, for divide mode;
- a gate enable, `clk_gate_o`, that an external clock gate uses to pass the adapter clock;
- a one-cycle strobe, `clk_rise_o`, at the start of each card-clock period. The command and data paths use this strobe as their shift enable.

When power saving is enabled, the clock stops by itself after both paths have been idle for a set number of card-clock periods. It resumes as soon as either path becomes busy. Configuration fields arrive as plain input ports.

Top module: `sdclk_pwr_ctrl`

## Requirements
- R1: `pwr_mode_i` encodes the phase as follows: 2'b00 is power-off, 2'b10 is power-up and 2'b11 is power-on. The value 2'b01 is treated as power-off.
- R2: `drv_en_o` is high only in the power-on phase. It follows a change of `pwr_mode_i` one adapter cycle later.
- R3: After reset and in any phase other than power-on, `clk_rise_o`, `clk_gate_o` and `card_clk_o` are all low. Entering power-on produces a strobe in the same cycle that `drv_en_o` rises.
- R4: In divide mode the card-clock period is `div_i + 2` adapter cycles.
- R5: In divide mode `card_clk_o` is high for floor((`div_i`+2)/2) cycles of each period, starting in the strobe cycle.
- R6: `clk_rise_o` is high for exactly one adapter cycle, at the first cycle of each card-clock period.
- R7: A new `div_i` or `bypass_i` value is taken only at a period boundary. The period in progress ends with its old length, and the periods after it use the new length.
- R8: With `bypass_i` high, `clk_rise_o` and `clk_gate_o` are high on every cycle and `card_clk_o` stays low, whatever the value of `div_i`.
- R9: With `psave_i` high and both `cmd_idle_i` and `dat_idle_i` high, exactly 8 further strobes occur. After those, `clk_gate_o` drops and the strobes stop.
- R10: Once stopped, the clock restarts one adapter cycle after either idle input falls. The first restarted cycle carries a strobe.
- R11: With `psave_i` low, the clock never stops while in power-on, even if both paths are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Adapter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_mode_i | input | 2 | Requested power phase (R1 encoding) |
| div_i | input | 8 | Divider field; period is div_i+2 |
| bypass_i | input | 1 | Pass the adapter clock through undivided |
| psave_i | input | 1 | Enable automatic stop when both paths are idle |
| cmd_idle_i | input | 1 | Command path is idle |
| dat_idle_i | input | 1 | Data path is idle |
| card_clk_o | output | 1 | Divided card clock level |
| clk_gate_o | output | 1 | Card clock running (gate enable) |
| clk_rise_o | output | 1 | One-cycle strobe at each card-clock rising edge |
| drv_en_o | output | 1 | Card bus output driver enable |

## Verification
The assertions assume that `pwr_mode_i`, `psave_i` and the idle inputs are synchronous to the adapter clock and change only between edges. They also assume that the idle inputs say nothing about clock gating beyond their own level. The bench drives every input shortly after the falling edge and holds it for whole cycles, so each property sees clean, single-valued inputs. Period lengths are measured only after the configuration has been stable for at least one full period, except in the boundary test, which deliberately changes the divider in the middle of a period.

// File: rtl/sdcp_pkg.sv
package sdcp_pkg;
    typedef enum logic [1:0] {
        PWR_OFF  = 2'b00,
        PWR_RSVD = 2'b01,
        PWR_UP   = 2'b10,
        PWR_ON   = 2'b11
    } pwr_mode_e;

    localparam int unsigned DEF_DIV_W        = 8;
    localparam int unsigned DEF_IDLE_PERIODS = 8;
endpackage

// File: rtl/sdcp_power.sv
module sdcp_power
    import sdcp_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] mode_i,
    output logic       pwr_on_o
);
    typedef struct packed {
        logic on;
    } pwr_state_t;

    pwr_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        // only the full power-on phase enables the bus; reserved code acts as off
        st_d.on = (pwr_mode_e'(mode_i) == PWR_ON);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pwr_on_o = st_q.on;
endmodule

// File: rtl/sdcp_divider.sv
module sdcp_divider #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             bypass_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             rise_o,
    output logic             level_o
);
    localparam int unsigned PER_W = DIV_W + 1;

    typedef struct packed {
        logic [PER_W-1:0] cnt;
        logic [PER_W-1:0] per;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [PER_W-1:0] next_per;
    logic             last;

    always_comb begin
        next_per = bypass_i ? PER_W'(1) : (PER_W'(div_i) + PER_W'(2));
        last     = (st_q.cnt == st_q.per - PER_W'(1));
        st_d     = st_q;
        if (!run_i) begin
            // parked: restart from the period start with the current setting
            st_d.cnt = '0;
            st_d.per = next_per;
        end else if (last) begin
            // period boundary: the only point where a new setting is taken
            st_d.cnt = '0;
            st_d.per = next_per;
        end else begin
            st_d.cnt = st_q.cnt + PER_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
            st_q.per <= PER_W'(2);
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o  = run_i && (st_q.cnt == '0);
    assign level_o = run_i && (st_q.cnt < (st_q.per >> 1));
endmodule

// File: rtl/sdcp_idle_gate.sv
module sdcp_idle_gate #(
    parameter int unsigned IDLE_PERIODS = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwr_on_i,
    input  logic psave_i,
    input  logic cmd_idle_i,
    input  logic dat_idle_i,
    input  logic rise_i,
    output logic stop_o
);
    localparam int unsigned CW = $clog2(IDLE_PERIODS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_PERIODS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          stop;
    } idle_state_t;

    idle_state_t st_d, st_q;
    logic        both_idle;

    always_comb begin
        both_idle = cmd_idle_i && dat_idle_i;
        st_d      = st_q;
        if (!pwr_on_i || !psave_i || !both_idle) begin
            st_d.cnt  = '0;
            st_d.stop = 1'b0;
        end else begin
            if (rise_i && (st_q.cnt < LIMIT)) st_d.cnt = st_q.cnt + CW'(1);
            st_d.stop = (st_d.cnt == LIMIT);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stop_o = st_q.stop;
endmodule

// File: rtl/sdclk_pwr_ctrl.sv
module sdclk_pwr_ctrl
    import sdcp_pkg::*;
#(
    parameter int unsigned DIV_W        = DEF_DIV_W,
    parameter int unsigned IDLE_PERIODS = DEF_IDLE_PERIODS
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [1:0]       pwr_mode_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             bypass_i,
    input  logic             psave_i,
    input  logic             cmd_idle_i,
    input  logic             dat_idle_i,
    output logic             card_clk_o,
    output logic             clk_gate_o,
    output logic             clk_rise_o,
    output logic             drv_en_o
);
    logic pwr_on;
    logic stop;
    logic run;
    logic rise;
    logic level;

    sdcp_power u_power (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .mode_i  (pwr_mode_i),
        .pwr_on_o(pwr_on)
    );

    assign run = pwr_on && !stop;

    sdcp_divider #(.DIV_W(DIV_W)) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .bypass_i(bypass_i),
        .div_i   (div_i),
        .rise_o  (rise),
        .level_o (level)
    );

    sdcp_idle_gate #(.IDLE_PERIODS(IDLE_PERIODS)) u_idle (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pwr_on_i  (pwr_on),
        .psave_i   (psave_i),
        .cmd_idle_i(cmd_idle_i),
        .dat_idle_i(dat_idle_i),
        .rise_i    (rise),
        .stop_o    (stop)
    );

    assign card_clk_o = level;
    assign clk_gate_o = run;
    assign clk_rise_o = rise;
    assign drv_en_o   = pwr_on;
endmodule

// File: rtl/sdcp_checker.sv
module sdcp_checker (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [1:0] pwr_mode_i,
    input logic       psave_i,
    input logic       cmd_idle_i,
    input logic       dat_idle_i,
    input logic       card_clk_o,
    input logic       clk_gate_o,
    input logic       clk_rise_o,
    input logic       drv_en_o
);
    a_r2_drv_follows_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pwr_mode_i != 2'b11) |=> !drv_en_o);

    a_r3_quiet_unpowered: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drv_en_o |-> (!clk_rise_o && !clk_gate_o && !card_clk_o));

    a_r6_strobe_only_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_rise_o || card_clk_o) |-> clk_gate_o);

    a_r10_restart_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drv_en_o && pwr_mode_i == 2'b11 && !(cmd_idle_i && dat_idle_i)) |=> clk_gate_o);

    a_r11_no_stop_without_psave: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drv_en_o && pwr_mode_i == 2'b11 && !psave_i) |=> clk_gate_o);

    a_r3_power_on_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(drv_en_o) |-> clk_rise_o);
endmodule

bind sdclk_pwr_ctrl sdcp_checker u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_mode_i(pwr_mode_i),
    .psave_i   (psave_i),
    .cmd_idle_i(cmd_idle_i),
    .dat_idle_i(dat_idle_i),
    .card_clk_o(card_clk_o),
    .clk_gate_o(clk_gate_o),
    .clk_rise_o(clk_rise_o),
    .drv_en_o  (drv_en_o)
);

// File: tb/sim_sdclk_pwr_ctrl.sv
`timescale 1ns/1ps
module sim_sdclk_pwr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] div = 8'd0;
    logic       byp = 1'b0;
    logic       psave = 1'b0;
    logic       cidle = 1'b0;
    logic       didle = 1'b0;
    logic       card_clk, gate, rise, drv;

    always #10 clk = ~clk;

    sdclk_pwr_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .pwr_mode_i(mode), .div_i(div),
        .bypass_i(byp), .psave_i(psave), .cmd_idle_i(cidle), .dat_idle_i(didle),
        .card_clk_o(card_clk), .clk_gate_o(gate), .clk_rise_o(rise), .drv_en_o(drv)
    );

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_rise = -1;
    int hi_run = 0;
    bit armed = 0;
    int got_per[$];
    int got_hi[$];
    int exp_per[$];
    int exp_hi[$];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: records period length and high time of each completed period
    always @(negedge clk) begin
        if (rise) begin
            if (armed && last_rise >= 0) begin
                got_per.push_back(cyc - last_rise);
                got_hi.push_back(hi_run);
            end
            last_rise = cyc;
            hi_run = 0;
        end
        if (card_clk) hi_run++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic arm();
        got_per.delete();
        got_hi.delete();
        last_rise = -1;
        armed = 1;
    endtask

    task automatic wait_periods(input int n);
        for (int i = 0; i < 3000 && got_per.size() < n; i++) step();
    endtask

    // driver: configures divide mode and pushes expected periods to the scoreboard
    task automatic run_divide(input int d, input int n);
        div = 8'(d);
        repeat (600) step();
        for (int i = 0; i < n; i++) begin
            exp_per.push_back(d + 2);
            exp_hi.push_back((d + 2) / 2);
        end
        arm();
        wait_periods(n);
        armed = 0;
        check(got_per.size() >= n, "R4 period count", got_per.size(), n);
        while (exp_per.size() > 0 && got_per.size() > 0) begin
            int e = exp_per.pop_front();
            int g = got_per.pop_front();
            int eh = exp_hi.pop_front();
            int gh = got_hi.pop_front();
            check(g == e, "R4 period", g, e);
            check(gh == eh, "R5 high time", gh, eh);
        end
        exp_per.delete();
        exp_hi.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int cnt;
        int cnt_hi;
        bit gate_all;
        repeat (3) step();
        // reset state (R3)
        check(!drv && !gate && !rise && !card_clk, "R3 reset outputs", {drv, gate, rise, card_clk}, 0);
        rst_n = 1'b1;
        repeat (3) step();
        check(!drv && !gate, "R3 after reset off", {drv, gate}, 0);

        // reserved encoding behaves as off (R1)
        mode = 2'b01;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin step(); if (rise || drv || gate) cnt++; end
        check(cnt == 0, "R1 reserved code is off", cnt, 0);

        // power-up phase: no clock, drivers off (R2, R3)
        mode = 2'b10;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin step(); if (rise || drv || card_clk) cnt++; end
        check(cnt == 0, "R3 power-up silent", cnt, 0);

        // power-on: driver enable and first strobe one cycle later (R2, R3)
        div = 8'd3;
        mode = 2'b11;
        step();
        check(drv == 1'b1, "R2 drv on", drv, 1);
        check(rise == 1'b1, "R3 first strobe", rise, 1);

        // divide ratios (R4, R5)
        run_divide(0, 4);
        run_divide(3, 4);
        run_divide(10, 3);
        run_divide(255, 2);

        // single-cycle strobe (R6)
        div = 8'd4;
        repeat (600) step();
        cnt = 0;
        for (int i = 0; i < 60; i++) begin step(); if (rise) cnt++; end
        check(cnt == 10, "R6 one strobe per period", cnt, 10);

        // boundary change (R7): div 6 (period 8) -> div 1 (period 3)
        div = 8'd6;
        repeat (600) step();
        arm();
        wait_periods(1);
        step();
        step();
        div = 8'd1;
        wait_periods(5);
        armed = 0;
        check(got_per.size() >= 4 && got_per[1] == 8, "R7 old period completes", got_per.size() >= 2 ? got_per[1] : -1, 8);
        check(got_per.size() >= 4 && got_per[2] == 3, "R7 new period used", got_per.size() >= 3 ? got_per[2] : -1, 3);
        check(got_per.size() >= 4 && got_per[3] == 3, "R7 new period steady", got_per.size() >= 4 ? got_per[3] : -1, 3);

        // bypass (R8)
        byp = 1'b1;
        repeat (10) step();
        cnt = 0; cnt_hi = 0; gate_all = 1;
        for (int i = 0; i < 12; i++) begin
            step();
            if (rise) cnt++;
            if (card_clk) cnt_hi++;
            if (!gate) gate_all = 0;
            if (i == 5) div = 8'd200;
        end
        check(cnt == 12, "R8 strobe every cycle", cnt, 12);
        check(cnt_hi == 0, "R8 level low", cnt_hi, 0);
        check(gate_all, "R8 gate high", gate_all, 1);
        byp = 1'b0;
        div = 8'd0;
        repeat (10) step();

        // power save without enable (R11)
        psave = 1'b0; cidle = 1'b1; didle = 1'b1;
        cnt = 0; gate_all = 1;
        for (int i = 0; i < 40; i++) begin step(); if (rise) cnt++; if (!gate) gate_all = 0; end
        check(cnt == 20 && gate_all, "R11 keeps running", cnt, 20);

        // power save stop after eight idle periods (R9)
        cidle = 1'b0;
        step();
        psave = 1'b1;
        step();
        cidle = 1'b1;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            if (rise) cnt++;
            if (!gate) break;
            step();
        end
        check(cnt == 8, "R9 strobes before stop", cnt, 8);
        check(!gate, "R9 gate off", gate, 0);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin step(); if (rise || card_clk) cnt++; end
        check(cnt == 0, "R9 stays stopped", cnt, 0);

        // restart on next cycle (R10)
        didle = 1'b0;
        step();
        check(gate && rise, "R10 restart with strobe", {gate, rise}, 3);

        // power off while running (R2, R3)
        mode = 2'b00;
        step();
        check(!drv, "R2 drv off", drv, 0);
        check(!gate && !rise && !card_clk, "R3 off silent", {gate, rise, card_clk}, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule